// File: doc/BRIEF.md
# GPIO Port Register Bank

This block holds the registers behind four 8-bit general-purpose I/O ports on a small memory-mapped byte bus. Three of the ports are writable. Each has an output latch, a per-bit direction register and a per-bit analog-select register. The fourth port is input-only and holds no latch. A read of a port's data register returns a per-bit mix: bits in input mode return the synchronized pin level, and bits in output mode return the latch. Some bits have fixed overrides. Pins marked analog return 0. The pin shared with the external reset function returns 1 while it is assigned to reset.

The bus takes full-byte writes and single-bit writes. A single-bit write sets or clears one bit of a register and leaves the other seven unchanged. The `PKG_PINS` parameter selects a package variant of 8, 10 or 16 pins. Bit positions that are absent on that package read as 0 and ignore writes. Pin inputs pass through two flops before the read mux. Read data is registered, so it appears one cycle after the read is issued.

Top module: `gpio_portbank`

## Requirements
- R1: A data-register bit whose direction bit is 1 (input) reads the synchronized pin level. A bit whose direction bit is 0 (output) reads the output latch.
- R2: A bit with analog-select 1 and direction 1 reads 0, whatever the pin level. A bit with analog-select 1 and direction 0 still reads the latch.
- R3: While `rst_pin_sel` is 1, bit 5 of port 12 reads 1 and its output enable `pin_oe[21]` is 0, even when that bit is in output mode.
- R4: Address map. Data registers sit at byte offset equal to the port number: 0x00 for port 0, 0x04 for port 4, 0x0C for port 12 and 0x0D for port 13. Direction registers sit at 0x20 plus the port number, and analog-select registers at 0x60 plus the port number. Every other address reads 0x00. A byte write (`bus_bitop`=0) loads `bus_wdata`.
- R5: A single-bit write (`bus_bitop`=1) loads `bus_bval` into bit `bus_bidx` of the addressed register and leaves the other bits unchanged.
- R6: Reset clears every latch and analog-select register to 0. It sets every implemented direction bit to 1 (input), so `pin_out` and `pin_oe` are all 0.
- R7: Port 13 is read-only. Only bit 7 is implemented, and it returns the synchronized pin. Writes to its data or direction address change nothing.
- R8: Implemented bit masks for ports 0, 4, 12 and 13. With 8 pins: 0x1A, 0x01, 0x20, 0x80. With 10 pins: 0x1F, 0x01, 0x20, 0x80. With 16 pins: 0xFF, 0x03, 0x26, 0x80. Unimplemented bits read 0 in every register and ignore writes.
- R9: `pin_out` carries each writable port's latch. A `pin_oe` bit is 1 only for an implemented bit in output mode. The latch changes only on a bus write.
- R10: `bus_rdata` changes only on the clock edge that samples a read (`bus_sel`=1, `bus_wr`=0) and holds between reads. A pin change becomes visible to a read sampled on the third rising edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_bitop | input | 1 | 1 = single-bit write, 0 = byte write |
| bus_addr | input | AW | Register byte address |
| bus_wdata | input | 8 | Byte write data |
| bus_bidx | input | 3 | Bit index for a single-bit write |
| bus_bval | input | 1 | Bit value for a single-bit write |
| rst_pin_sel | input | 1 | Port 12 bit 5 is assigned to the external reset |
| pin_in | input | 32 | Pin levels, bytes for ports 0, 4, 12, 13 from LSB |
| pin_out | output | 24 | Latch values, ports 0, 4, 12 from LSB |
| pin_oe | output | 24 | Output enables, ports 0, 4, 12 from LSB |
| bus_rdata | output | 8 | Registered read data |

## Verification
A corrupted latch shows on `pin_out` on the edge after the faulty write. It also shows on the next read of an output-mode bit. A wrong direction bit flips the read source of that bit and its `pin_oe` at the same time. Any error in the synchronizer shows up as a change in the read-back timing of a pin level, relative to the three-edge rule. A package mask that is wrong shows on the first byte write of 0xFF followed by a read-back of the same register.

// File: rtl/gpio_portbank.sv
module gpio_portbank #(
  parameter int PKG_PINS = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_bitop,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic [2:0]    bus_bidx,
  input  logic          bus_bval,
  input  logic          rst_pin_sel,
  input  logic [31:0]   pin_in,
  output logic [23:0]   pin_out,
  output logic [23:0]   pin_oe,
  output logic [7:0]    bus_rdata
);

  localparam int NPORT = 4;
  localparam int NWR = 3;
  localparam logic [NPORT-1:0][7:0] PNUM = {8'd13, 8'd12, 8'd4, 8'd0};
  localparam logic [7:0] DIR_BASE = 8'h20;
  localparam logic [7:0] ANA_BASE = 8'h60;
  localparam int RST_BIT = 5;

  function automatic logic [7:0] pmask(int k);
    case (k)
      0:       return (PKG_PINS == 8) ? 8'h1A : (PKG_PINS == 10) ? 8'h1F : 8'hFF;
      1:       return (PKG_PINS == 16) ? 8'h03 : 8'h01;
      2:       return (PKG_PINS == 16) ? 8'h26 : 8'h20;
      default: return 8'h80;
    endcase
  endfunction

  function automatic logic [7:0] upd(logic [7:0] cur, logic [7:0] m);
    logic [7:0] t;
    t = cur;
    if (bus_bitop) t[bus_bidx] = bus_bval;
    else t = bus_wdata;
    return t & m;
  endfunction

  logic [31:0] sync1, sync2;
  logic [NPORT-1:0][7:0] dv, mv, av;
  logic [7:0] rd_nx;
  wire wr_en = bus_sel & bus_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end
  end

  for (genvar k = 0; k < NWR; k++) begin : g_port
    localparam logic [7:0] M = pmask(k);
    localparam logic [7:0] RMSK = (k == 2) ? ~(8'h01 << RST_BIT) : 8'hFF;
    logic [7:0] lat, dir, ana, view;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lat <= '0;
        dir <= M;
        ana <= '0;
      end else if (wr_en) begin
        if (bus_addr == AW'(PNUM[k]))            lat <= upd(lat, M);
        if (bus_addr == AW'(DIR_BASE + PNUM[k])) dir <= upd(dir, M);
        if (bus_addr == AW'(ANA_BASE + PNUM[k])) ana <= upd(ana, M);
      end
    end

    always_comb begin
      for (int b = 0; b < 8; b++) begin
        if (!M[b])       view[b] = 1'b0;
        else if (dir[b]) view[b] = ana[b] ? 1'b0 : sync2[8*k+b];
        else             view[b] = lat[b];
      end
      if (k == 2 && rst_pin_sel) view[RST_BIT] = 1'b1;
    end

    assign dv[k] = view;
    assign mv[k] = dir;
    assign av[k] = ana;
    assign pin_out[8*k +: 8] = lat;
    assign pin_oe[8*k +: 8]  = ~dir & M & ((rst_pin_sel) ? RMSK : 8'hFF);
  end

  assign dv[3] = sync2[31:24] & pmask(3);
  assign mv[3] = '0;
  assign av[3] = '0;

  always_comb begin
    rd_nx = '0;
    for (int k = 0; k < NPORT; k++) begin
      if (bus_addr == AW'(PNUM[k]))            rd_nx = dv[k];
      if (bus_addr == AW'(DIR_BASE + PNUM[k])) rd_nx = mv[k];
      if (bus_addr == AW'(ANA_BASE + PNUM[k])) rd_nx = av[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_nx;
  end

endmodule

// File: rtl/gpio_portbank_chk.sv
module gpio_portbank_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic          bus_bitop,
  input logic [AW-1:0] bus_addr,
  input logic [2:0]    bus_bidx,
  input logic          rst_pin_sel,
  input logic [23:0]   pin_out,
  input logic          oe_rst,
  input logic [7:0]    bus_rdata
);

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_sel && bus_wr) |-> $stable(pin_out));

  // R5
  bit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_sel && bus_wr && bus_bitop && bus_addr == AW'(8'h00)) |->
      (((pin_out[7:0] ^ $past(pin_out[7:0])) & ~(8'h01 << $past(bus_bidx))) == 8'h00));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_sel && !bus_wr) |-> $stable(bus_rdata));

  // R3
  rst_pin_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_sel && !bus_wr && bus_addr == AW'(8'h0C) && rst_pin_sel) |-> bus_rdata[5]);

  // R3
  rst_pin_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pin_sel |-> !oe_rst);

  // R7
  ro_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_sel && !bus_wr && bus_addr == AW'(8'h0D)) |-> ((bus_rdata & 8'h7F) == 8'h00));

endmodule

bind gpio_portbank gpio_portbank_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_bitop(bus_bitop), .bus_addr(bus_addr), .bus_bidx(bus_bidx),
  .rst_pin_sel(rst_pin_sel), .pin_out(pin_out), .oe_rst(pin_oe[21]),
  .bus_rdata(bus_rdata)
);

// File: tb/sim_gpio_portbank.sv
module sim_gpio_portbank;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0, bus_bitop = 0, bus_bval = 0, rst_pin_sel = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0;
  logic [2:0] bus_bidx = 0;
  logic [31:0] pin_in = 0;
  logic [23:0] pout0, poe0, pout1, poe1;
  logic [7:0] rd0, rd1;
  int nchk = 0, nbad = 0;

  always #10 clk = ~clk;

  gpio_portbank #(.PKG_PINS(16)) u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_bitop(bus_bitop), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_bidx(bus_bidx),
    .bus_bval(bus_bval), .rst_pin_sel(rst_pin_sel), .pin_in(pin_in), .pin_out(pout0),
    .pin_oe(poe0), .bus_rdata(rd0));
  gpio_portbank #(.PKG_PINS(8)) u1 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_bitop(bus_bitop), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_bidx(bus_bidx),
    .bus_bval(bus_bval), .rst_pin_sel(rst_pin_sel), .pin_in(pin_in), .pin_out(pout1),
    .pin_oe(poe1), .bus_rdata(rd1));

  // {addr, wdata, expected read-back} for the 16-pin instance
  localparam int NV = 10;
  localparam logic [NV-1:0][23:0] VEC = {
    24'h2C_FF_26, 24'h60_00_00, 24'h60_FF_FF, 24'h0D_FF_00, 24'h0C_FF_26,
    24'h2C_00_00, 24'h04_FF_03, 24'h24_00_00, 24'h00_A5_A5, 24'h20_00_00};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_bitop = 0; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bwr(logic [7:0] a, logic [2:0] i, logic v);
    bus_sel = 1; bus_wr = 1; bus_bitop = 1; bus_addr = a; bus_bidx = i; bus_bval = v;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_bitop = 0;
  endtask

  task automatic rd(logic [7:0] a);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    chk("R6 pin_out", {8'h0, pout0}, 32'h0);
    chk("R6 pin_oe", {8'h0, poe0}, 32'h0);
    rd(8'h00); chk("R6 P0 data", rd0, 8'h00);
    rd(8'h20); chk("R6 P0 dir", rd0, 8'hFF);
    chk("R8 pkg8 P0 dir", rd1, 8'h1A);
    rd(8'h60); chk("R6 P0 analog", rd0, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][23:16], VEC[i][15:8]);
      rd(VEC[i][23:16]);
      chk("R4 R8 vector", rd0, VEC[i][7:0]);
    end

    chk("R9 pin_out P0", pout0[7:0], 8'hA5);
    chk("R9 pin_oe P0", poe0[7:0], 8'hFF);
    chk("R9 pin_oe P4", poe0[15:8], 8'h03);
    chk("R9 pin_oe P12 input", poe0[23:16], 8'h00);

    bwr(8'h00, 3'd1, 1'b1); rd(8'h00); chk("R5 set bit", rd0, 8'hA7);
    bwr(8'h00, 3'd7, 1'b0); rd(8'h00); chk("R5 clear bit", rd0, 8'h27);
    bwr(8'h04, 3'd5, 1'b1); rd(8'h04); chk("R8 unimpl bit write", rd0, 8'h03);
    bwr(8'h20, 3'd2, 1'b1); rd(8'h20); chk("R5 dir bit", rd0, 8'h04);
    rd(8'h00); chk("R1 mixed dir", rd0, 8'h23);

    pin_in[7:0] = 8'h3C; idle(3);
    wr(8'h20, 8'hFF); rd(8'h00); chk("R1 input pins", rd0, 8'h3C);
    chk("R9 oe off in input", poe0[7:0], 8'h00);

    pin_in[7:0] = 8'hC3;
    rd(8'h00); chk("R10 sync edge1", rd0, 8'h3C);
    rd(8'h00); chk("R10 sync edge2", rd0, 8'h3C);
    rd(8'h00); chk("R10 sync edge3", rd0, 8'hC3);
    idle(2); chk("R10 rdata hold", rd0, 8'hC3);

    pin_in[7:0] = 8'h3C; idle(3);
    wr(8'h60, 8'h2F);
    bwr(8'h20, 3'd5, 1'b0);
    rd(8'h00); chk("R2 analog read", rd0, 8'h30);

    bwr(8'h0C, 3'd5, 1'b0);
    wr(8'h2C, 8'h00);
    rd(8'h0C); chk("R1 P12 output", rd0, 8'h06);
    chk("R9 P12 oe", poe0[23:16], 8'h26);
    rst_pin_sel = 1; idle(1);
    rd(8'h0C); chk("R3 reset pin reads 1", rd0, 8'h26);
    chk("R3 reset pin oe", poe0[23:16], 8'h06);
    rst_pin_sel = 0; idle(1);

    pin_in[31:24] = 8'hFF; idle(3);
    rd(8'h0D); chk("R7 P13 read", rd0, 8'h80);
    wr(8'h0D, 8'h00); wr(8'h2D, 8'hFF);
    rd(8'h0D); chk("R7 P13 write ignored", rd0, 8'h80);
    rd(8'h2D); chk("R7 P13 no dir", rd0, 8'h00);

    wr(8'h20, 8'h00); wr(8'h00, 8'hFF);
    rd(8'h00); chk("R8 pkg16 P0", rd0, 8'hFF); chk("R8 pkg8 P0", rd1, 8'h1A);
    rd(8'h04); chk("R8 pkg16 P4", rd0, 8'h03); chk("R8 pkg8 P4", rd1, 8'h01);
    wr(8'h2C, 8'hFF);
    rd(8'h2C); chk("R8 pkg16 P12 dir", rd0, 8'h26); chk("R8 pkg8 P12 dir", rd1, 8'h20);
    rd(8'h30); chk("R4 unmapped", rd0, 8'h00);

    pin_in = 0;
    rst_n = 0; idle(2); rst_n = 1; idle(3);
    chk("R6 reset pin_out", {8'h0, pout0}, 32'h0);
    chk("R6 reset pin_oe", {8'h0, poe0}, 32'h0);
    rd(8'h0C); chk("R6 reset P12", rd0, 8'h00);

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule